// File: doc/BRIEF.md
# Fetch-to-Decode Instruction Queue with Partial Removal

This block sits between instruction fetch and decode. Fetch pushes a whole group of up to `GMAX` sequential instructions in one cycle. Decode takes up to `DW` of them per cycle, oldest first. A group wider than the decode width leaves its surplus waiting in the queue for later cycles. Every stored instruction keeps the group tag it arrived with and its lane position inside that group, called its slot. Later control inputs use the tag and slot to name a single instruction.

Two kinds of partial removal act on the stored stream.

- **Resteer.** A resteer names a branch. Everything up to and including that branch stays, and everything fetched after it is dropped. This is a lighter operation than the full flush, which empties the queue.
- **Short forward skip.** Fetch can run straight through a short forward branch that was predicted taken. A skip command then names that branch and the number of instructions it jumps over (1 to `MAX_SKIP`). Those entries are marked dead in place. Dequeue steps over them in the same cycle, so decode sees exactly the stream that a taken redirect would have given.

Top module: `fetch_insn_queue`

## Requirements
- R1: After synchronous active-low reset the queue is empty: `deq_valid` is all zero and `enq_ready` is 1.
- R2: When `enq_valid` is high, `enq_ready` is high and `enq_cnt` is 1 to `GMAX`, lanes 0 to `enq_cnt`-1 of `enq_insn` are appended in lane order. Each appended entry records `enq_tag` as its tag and its lane number as its slot.
- R3: `enq_ready` is 1 exactly when at least `GMAX` entries are free. The free count includes dead entries not yet stepped over. A group offered while `enq_ready` is 0 is not stored.
- R4: Dequeue presents up to `DW` live entries on lanes packed from lane 0, oldest on lane 0. Each lane carries its instruction, tag and slot. They are consumed on a cycle with `deq_ready` high.
- R5: A group larger than `DW` is delivered over several consecutive cycles, in order, with nothing lost.
- R6: A resteer that names an entry present in the queue keeps that entry and every older entry, and discards every younger one. An enqueue offered in the same cycle is dropped.
- R7: A resteer whose tag and slot match no entry present in the queue leaves the contents unchanged.
- R8: A flush empties the queue and takes priority over a resteer, a skip and an enqueue offered in the same cycle.
- R9: A skip with length L from 1 to `MAX_SKIP` kills the stored entries whose tag equals `skip_tag` and whose slot lies from `skip_slot`+1 to `skip_slot`+L. The branch itself stays.
- R10: A skip with length 0 or above `MAX_SKIP` removes nothing.
- R11: Dequeue examines the oldest `DW`+`MAX_SKIP` entries. It presents the first `DW` live ones among them. It retires everything up to the last entry presented, including the dead entries before it. If fewer than `DW` live entries exist in that window, it retires the whole window.
- R12: In a cycle that carries a flush, a resteer or a skip, `deq_valid` is all zero and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the whole queue |
| enq_valid | input | 1 | A fetch group is offered |
| enq_cnt | input | $clog2(GMAX+1) | Number of instructions in the group |
| enq_tag | input | TAG_W | Tag of the offered group |
| enq_insn | input | GMAX*IW | Group instructions, lane 0 in the low bits |
| enq_ready | output | 1 | At least GMAX entries are free |
| resteer_valid | input | 1 | Truncate after a named branch |
| resteer_tag | input | TAG_W | Group tag of the named branch |
| resteer_slot | input | $clog2(GMAX) | Slot of the named branch |
| skip_valid | input | 1 | Remove the instructions a short forward branch jumps over |
| skip_tag | input | TAG_W | Group tag of that branch |
| skip_slot | input | $clog2(GMAX) | Slot of that branch |
| skip_len | input | $clog2(MAX_SKIP+1)+1 | Number of skipped instructions |
| deq_ready | input | 1 | Decode consumes the presented lanes |
| deq_valid | output | DW | Lane valid bits, packed from lane 0 |
| deq_insn | output | DW*IW | Instruction per lane |
| deq_tag | output | DW*TAG_W | Group tag per lane |
| deq_slot | output | DW*$clog2(GMAX) | Slot per lane |

## Verification
The bench builds the block with a depth of 32, a group size of 16, a decode width of 8, a skip limit of 4 and 6-bit tags. With these values two full groups fill the queue, so `enq_ready` falls at 17 entries. A 16-wide group takes exactly two drain cycles. The 12-entry dequeue window can meet a hole of every legal length, and can also run short of live entries when several holes gather near the head. The 6-bit tags stay unique across every group the queue can hold, so each resteer and skip names a single entry.

// File: rtl/fiq_pkg.sv
// Shared types for the fetch instruction queue.
// Assumes: nothing beyond the standard language.
package fiq_pkg;
    // Control action applied in a cycle, already resolved by priority.
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_FLUSH   = 2'd1,
        OP_RESTEER = 2'd2,
        OP_EXCISE  = 2'd3
    } fiq_op_e;
endpackage

// File: rtl/fiq_ptr_ctrl.sv
// Head and tail pointers of the circular queue, occupancy and the
// enqueue-ready flag.
// Assumes: DEPTH is a power of two and DEPTH >= GMAX. The caller blocks
// deq_fire outside OP_IDLE and blocks enq_fire during a flush or resteer.
module fiq_ptr_ctrl
    import fiq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int GMAX  = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(GMAX + 1),
    parameter int ADV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fiq_op_e          op,
    input  logic             rs_hit,
    input  logic [PTR_W-1:0] rs_off,
    input  logic             enq_fire,
    input  logic [CNT_W-1:0] enq_cnt,
    input  logic             deq_fire,
    input  logic [ADV_W-1:0] deq_adv,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [PTR_W:0]   count,
    output logic             enq_ready
);
    localparam int PW1 = PTR_W + 1;

    logic [PW1-1:0] head_q, tail_q, head_n, tail_n;

    // Next-pointer selection by the resolved control action.
    always_comb begin
        head_n = head_q;
        tail_n = tail_q;
        case (op)
            OP_FLUSH: begin
                head_n = '0;
                tail_n = '0;
            end
            OP_RESTEER: begin
                if (rs_hit) tail_n = head_q + PW1'(rs_off) + PW1'(1);
            end
            default: begin
                if (deq_fire) head_n = head_q + PW1'(deq_adv);
                if (enq_fire) tail_n = tail_q + PW1'(enq_cnt);
            end
        endcase
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
        end
    end

    assign count     = tail_q - head_q;
    assign head_idx  = head_q[PTR_W-1:0];
    assign tail_idx  = tail_q[PTR_W-1:0];
    assign enq_ready = count <= PW1'(DEPTH - GMAX);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW1'(DEPTH));
    a_r3_refuse_when_short: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_ready |-> !enq_fire);
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FLUSH |=> count == '0);
    a_r6_truncate_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESTEER && rs_hit) |=> count == PW1'($past(rs_off)) + PW1'(1));
    a_r7_miss_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESTEER && !rs_hit) |=> ($stable(head_idx) && $stable(count)));
endmodule

// File: rtl/fiq_entry_array.sv
// Entry storage: instruction, group tag, slot and live bit per entry.
// Writes arriving groups, finds the resteer target and kills the entries
// jumped over by a short forward branch.
// Assumes: group tags of entries present in the queue are unique, and a
// group is only written into free entries.
module fiq_entry_array
    import fiq_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int GMAX     = 16,
    parameter int IW       = 32,
    parameter int TAG_W    = 6,
    parameter int MAX_SKIP = 4,
    parameter int PTR_W    = $clog2(DEPTH),
    parameter int SLOT_W   = $clog2(GMAX),
    parameter int CNT_W    = $clog2(GMAX + 1),
    parameter int LEN_W    = $clog2(MAX_SKIP + 1) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  fiq_op_e                      op,
    input  logic [PTR_W-1:0]             head_idx,
    input  logic [PTR_W-1:0]             tail_idx,
    input  logic [PTR_W:0]               count,
    input  logic                         enq_fire,
    input  logic [CNT_W-1:0]             enq_cnt,
    input  logic [TAG_W-1:0]             enq_tag,
    input  logic [GMAX-1:0][IW-1:0]      enq_insn,
    input  logic [TAG_W-1:0]             rs_tag,
    input  logic [SLOT_W-1:0]            rs_slot,
    input  logic [TAG_W-1:0]             sk_tag,
    input  logic [SLOT_W-1:0]            sk_slot,
    input  logic [LEN_W-1:0]             sk_len,
    output logic [DEPTH-1:0][IW-1:0]     ent_insn,
    output logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
    output logic [DEPTH-1:0][SLOT_W-1:0] ent_slot,
    output logic [DEPTH-1:0]             ent_live,
    output logic                         rs_hit,
    output logic [PTR_W-1:0]             rs_off
);
    localparam int PW1 = PTR_W + 1;
    localparam int SW1 = SLOT_W + 1;

    logic [DEPTH-1:0][IW-1:0]     insn_q;
    logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
    logic [DEPTH-1:0][SLOT_W-1:0] slot_q;
    logic [DEPTH-1:0]             live_q;

    logic [DEPTH-1:0][PTR_W-1:0]  age_off;
    logic [DEPTH-1:0][SLOT_W-1:0] wr_lane;
    logic [DEPTH-1:0]             occ, we, kill, rs_match;
    logic                         len_ok, excise_go;

    assign len_ok    = (sk_len != '0) && (sk_len <= LEN_W'(MAX_SKIP));
    assign excise_go = (op == OP_EXCISE) && len_ok;

    // Per-entry decode: age from head, lane from tail, match and kill terms.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic [PTR_W-1:0] EIDX = PTR_W'(e);
        logic [PTR_W-1:0] woff;

        assign age_off[e]  = EIDX - head_idx;
        assign woff        = EIDX - tail_idx;
        assign wr_lane[e]  = woff[SLOT_W-1:0];
        assign occ[e]      = {1'b0, age_off[e]} < count;
        assign we[e]       = enq_fire && ({1'b0, woff} < PW1'(enq_cnt));
        assign rs_match[e] = occ[e] && (tag_q[e] == rs_tag) && (slot_q[e] == rs_slot);
        assign kill[e]     = excise_go && occ[e] && (tag_q[e] == sk_tag)
                          && (slot_q[e] > sk_slot)
                          && ({1'b0, slot_q[e]} <= ({1'b0, sk_slot} + SW1'(sk_len)));

        a_r9_hole_dead: assert property (@(posedge clk) disable iff (!rst_n)
            kill[e] |=> !ent_live[e]);
        a_r2_tag_recorded: assert property (@(posedge clk) disable iff (!rst_n)
            we[e] |=> (ent_live[e] && ent_tag[e] == $past(enq_tag)));
    end

    // Resteer target position, measured from the head.
    always_comb begin
        rs_off = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (rs_match[e]) rs_off = age_off[e];
        end
    end
    assign rs_hit = |rs_match;

    // Payload storage, written only for the lanes of an accepted group.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (we[e]) begin
                insn_q[e] <= enq_insn[wr_lane[e]];
                tag_q[e]  <= enq_tag;
                slot_q[e] <= wr_lane[e];
            end
        end
    end

    // Live bits: set on write, cleared when a skip removes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (we[e])        live_q[e] <= 1'b1;
                else if (kill[e]) live_q[e] <= 1'b0;
            end
        end
    end

    assign ent_insn = insn_q;
    assign ent_tag  = tag_q;
    assign ent_slot = slot_q;
    assign ent_live = live_q;

    a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rs_match));
endmodule

// File: rtl/fiq_deq_select.sv
// Dequeue selection: scans a window of the oldest entries, packs the live
// ones onto the decode lanes and reports how far the head may advance.
// Assumes: DW + MAX_SKIP <= DEPTH.
module fiq_deq_select #(
    parameter int DEPTH    = 32,
    parameter int DW       = 8,
    parameter int MAX_SKIP = 4,
    parameter int IW       = 32,
    parameter int TAG_W    = 6,
    parameter int SLOT_W   = 4,
    parameter int PTR_W    = $clog2(DEPTH),
    parameter int ADV_W    = $clog2(DW + MAX_SKIP + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PTR_W-1:0]             head_idx,
    input  logic [PTR_W:0]               count,
    input  logic [DEPTH-1:0][IW-1:0]     ent_insn,
    input  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
    input  logic [DEPTH-1:0][SLOT_W-1:0] ent_slot,
    input  logic [DEPTH-1:0]             ent_live,
    output logic [DW-1:0]                lane_vld,
    output logic [DW-1:0][IW-1:0]        lane_insn,
    output logic [DW-1:0][TAG_W-1:0]     lane_tag,
    output logic [DW-1:0][SLOT_W-1:0]    lane_slot,
    output logic [ADV_W-1:0]             adv
);
    localparam int SCAN = DW + MAX_SKIP;
    localparam int LW   = (DW > 1) ? $clog2(DW) : 1;

    // Walk the window oldest first, filling lanes and counting retired entries.
    always_comb begin
        logic [PTR_W-1:0] idx;
        logic [LW-1:0]    ln;
        int               nv;
        lane_vld  = '0;
        lane_insn = '0;
        lane_tag  = '0;
        lane_slot = '0;
        adv       = '0;
        nv        = 0;
        for (int k = 0; k < SCAN; k++) begin
            idx = head_idx + PTR_W'(k);
            ln  = LW'(nv);
            if (k < int'(count) && nv < DW) begin
                if (ent_live[idx]) begin
                    lane_vld[ln]  = 1'b1;
                    lane_insn[ln] = ent_insn[idx];
                    lane_tag[ln]  = ent_tag[idx];
                    lane_slot[ln] = ent_slot[idx];
                    nv = nv + 1;
                end
                adv = ADV_W'(k + 1);
            end
        end
    end

    a_r4_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_vld + DW'(1)) & lane_vld) == '0);
    a_r11_retire_covers_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_vld) <= int'(adv));
    a_r11_retire_within_queue: assert property (@(posedge clk) disable iff (!rst_n)
        int'(adv) <= int'(count));
endmodule

// File: rtl/fetch_insn_queue.sv
// Fetch-to-decode instruction queue. Wide fetch groups in, up to DW
// instructions out per cycle. A resteer truncates after a named branch,
// and a skip kills the instructions a short forward branch jumps over.
// Assumes: DEPTH is a power of two, DEPTH >= GMAX, DEPTH >= DW + MAX_SKIP,
// and group tags present in the queue are unique.
module fetch_insn_queue
    import fiq_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int GMAX     = 16,
    parameter int DW       = 8,
    parameter int IW       = 32,
    parameter int TAG_W    = 6,
    parameter int MAX_SKIP = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic                                  enq_valid,
    input  logic [$clog2(GMAX+1)-1:0]             enq_cnt,
    input  logic [TAG_W-1:0]                      enq_tag,
    input  logic [GMAX*IW-1:0]                    enq_insn,
    output logic                                  enq_ready,
    input  logic                                  resteer_valid,
    input  logic [TAG_W-1:0]                      resteer_tag,
    input  logic [$clog2(GMAX)-1:0]               resteer_slot,
    input  logic                                  skip_valid,
    input  logic [TAG_W-1:0]                      skip_tag,
    input  logic [$clog2(GMAX)-1:0]               skip_slot,
    input  logic [$clog2(MAX_SKIP+1):0]           skip_len,
    input  logic                                  deq_ready,
    output logic [DW-1:0]                         deq_valid,
    output logic [DW*IW-1:0]                      deq_insn,
    output logic [DW*TAG_W-1:0]                   deq_tag,
    output logic [DW*$clog2(GMAX)-1:0]            deq_slot
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int SLOT_W = $clog2(GMAX);
    localparam int CNT_W  = $clog2(GMAX + 1);
    localparam int LEN_W  = $clog2(MAX_SKIP + 1) + 1;
    localparam int ADV_W  = $clog2(DW + MAX_SKIP + 1);

    fiq_op_e                     op;
    logic                        enq_fire, deq_fire, rs_hit, ready_i;
    logic [PTR_W-1:0]            head_idx, tail_idx, rs_off;
    logic [PTR_W:0]              count;
    logic [ADV_W-1:0]            adv;
    logic [DEPTH-1:0][IW-1:0]    ent_insn;
    logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
    logic [DEPTH-1:0][SLOT_W-1:0] ent_slot;
    logic [DEPTH-1:0]            ent_live;
    logic [DW-1:0]               lane_vld;
    logic [DW-1:0][IW-1:0]       lane_insn;
    logic [DW-1:0][TAG_W-1:0]    lane_tag;
    logic [DW-1:0][SLOT_W-1:0]   lane_slot;

    // Resolve one control action per cycle: flush, then resteer, then skip.
    always_comb begin
        if (flush)              op = OP_FLUSH;
        else if (resteer_valid) op = OP_RESTEER;
        else if (skip_valid)    op = OP_EXCISE;
        else                    op = OP_IDLE;
    end

    // A group enters only in a quiet or skip cycle, with room and a legal size.
    assign enq_fire = enq_valid && ready_i && (op == OP_IDLE || op == OP_EXCISE)
                   && (enq_cnt != '0) && (enq_cnt <= CNT_W'(GMAX));
    // Decode consumes only in cycles without a control action.
    assign deq_fire = deq_ready && (op == OP_IDLE);

    fiq_ptr_ctrl #(
        .DEPTH(DEPTH), .GMAX(GMAX), .PTR_W(PTR_W), .CNT_W(CNT_W), .ADV_W(ADV_W)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(op), .rs_hit(rs_hit), .rs_off(rs_off),
        .enq_fire(enq_fire), .enq_cnt(enq_cnt), .deq_fire(deq_fire),
        .deq_adv(adv), .head_idx(head_idx), .tail_idx(tail_idx),
        .count(count), .enq_ready(ready_i)
    );

    fiq_entry_array #(
        .DEPTH(DEPTH), .GMAX(GMAX), .IW(IW), .TAG_W(TAG_W), .MAX_SKIP(MAX_SKIP),
        .PTR_W(PTR_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .op(op), .head_idx(head_idx),
        .tail_idx(tail_idx), .count(count), .enq_fire(enq_fire),
        .enq_cnt(enq_cnt), .enq_tag(enq_tag), .enq_insn(enq_insn),
        .rs_tag(resteer_tag), .rs_slot(resteer_slot),
        .sk_tag(skip_tag), .sk_slot(skip_slot), .sk_len(skip_len),
        .ent_insn(ent_insn), .ent_tag(ent_tag), .ent_slot(ent_slot),
        .ent_live(ent_live), .rs_hit(rs_hit), .rs_off(rs_off)
    );

    fiq_deq_select #(
        .DEPTH(DEPTH), .DW(DW), .MAX_SKIP(MAX_SKIP), .IW(IW), .TAG_W(TAG_W),
        .SLOT_W(SLOT_W), .PTR_W(PTR_W), .ADV_W(ADV_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .head_idx(head_idx), .count(count),
        .ent_insn(ent_insn), .ent_tag(ent_tag), .ent_slot(ent_slot),
        .ent_live(ent_live), .lane_vld(lane_vld), .lane_insn(lane_insn),
        .lane_tag(lane_tag), .lane_slot(lane_slot), .adv(adv)
    );

    assign enq_ready = ready_i;
    assign deq_valid = (op == OP_IDLE) ? lane_vld : '0;
    assign deq_insn  = lane_insn;
    assign deq_tag   = lane_tag;
    assign deq_slot  = lane_slot;

    a_r12_quiet_on_control: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || resteer_valid || skip_valid) |-> deq_valid == '0);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (enq_ready && deq_valid == '0) || !rst_n || op != OP_IDLE);
endmodule

// File: tb/tb_fetch_insn_queue.sv
`timescale 1ns/1ps
module tb_fetch_insn_queue;
    localparam int DEPTH    = 32;
    localparam int GMAX     = 16;
    localparam int DW       = 8;
    localparam int IW       = 32;
    localparam int TAG_W    = 6;
    localparam int MAX_SKIP = 4;
    localparam int SLOT_W   = $clog2(GMAX);
    localparam int CNT_W    = $clog2(GMAX + 1);
    localparam int LEN_W    = $clog2(MAX_SKIP + 1) + 1;
    localparam int SCAN     = DW + MAX_SKIP;
    localparam int CLK_NS   = 8;

    typedef struct packed {
        logic [IW-1:0]     insn;
        logic [TAG_W-1:0]  tag;
        logic [SLOT_W-1:0] slot;
        logic              live;
    } ment_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush, enq_valid, resteer_valid, skip_valid, deq_ready;
    logic [CNT_W-1:0]     enq_cnt;
    logic [TAG_W-1:0]     enq_tag, resteer_tag, skip_tag;
    logic [GMAX*IW-1:0]   enq_insn;
    logic [SLOT_W-1:0]    resteer_slot, skip_slot;
    logic [LEN_W-1:0]     skip_len;
    logic                 enq_ready;
    logic [DW-1:0]        deq_valid;
    logic [DW*IW-1:0]     deq_insn;
    logic [DW*TAG_W-1:0]  deq_tag;
    logic [DW*SLOT_W-1:0] deq_slot;

    always #(CLK_NS/2) clk = ~clk;

    fetch_insn_queue #(
        .DEPTH(DEPTH), .GMAX(GMAX), .DW(DW), .IW(IW), .TAG_W(TAG_W), .MAX_SKIP(MAX_SKIP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .enq_valid(enq_valid),
        .enq_cnt(enq_cnt), .enq_tag(enq_tag), .enq_insn(enq_insn),
        .enq_ready(enq_ready), .resteer_valid(resteer_valid),
        .resteer_tag(resteer_tag), .resteer_slot(resteer_slot),
        .skip_valid(skip_valid), .skip_tag(skip_tag), .skip_slot(skip_slot),
        .skip_len(skip_len), .deq_ready(deq_ready), .deq_valid(deq_valid),
        .deq_insn(deq_insn), .deq_tag(deq_tag), .deq_slot(deq_slot)
    );

    ment_t mq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    logic [TAG_W-1:0] next_tag = '0;
    int    obs_n;
    bit    obs_rdy;
    int    obs_slot[DW];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; enq_valid = 0; enq_cnt = '0; enq_tag = '0; enq_insn = '0;
        resteer_valid = 0; resteer_tag = '0; resteer_slot = '0;
        skip_valid = 0; skip_tag = '0; skip_slot = '0; skip_len = '0;
        deq_ready = 0;
    endtask

    task automatic offer_group(input int cnt);
        enq_valid = 1;
        enq_cnt   = CNT_W'(cnt);
        enq_tag   = next_tag;
        for (int i = 0; i < GMAX; i++) enq_insn[i*IW +: IW] = $urandom;
    endtask

    // One clock: check outputs against the model, then advance the model.
    task automatic cycle(input string req);
        int n, adv, j;
        bit rdy, quiet;
        logic [DW-1:0] mask;
        ment_t el[DW];
        ment_t ne;
        #1;
        rdy   = (DEPTH - mq.size()) >= GMAX;
        quiet = flush || resteer_valid || skip_valid;
        n = 0; adv = 0;
        if (!quiet) begin
            for (int k = 0; k < SCAN && k < mq.size() && n < DW; k++) begin
                if (mq[k].live) begin el[n] = mq[k]; n++; end
                adv = k + 1;
            end
        end
        mask = DW'((1 << n) - 1);
        chk(enq_ready === rdy, "R3", "enq_ready", longint'(enq_ready), longint'(rdy));
        chk(deq_valid === mask, req, "deq_valid", longint'(deq_valid), longint'(mask));
        for (int l = 0; l < n; l++) begin
            chk({deq_insn[l*IW +: IW], deq_tag[l*TAG_W +: TAG_W], deq_slot[l*SLOT_W +: SLOT_W]}
                === {el[l].insn, el[l].tag, el[l].slot}, req, "lane",
                longint'({deq_insn[l*IW +: IW], deq_tag[l*TAG_W +: TAG_W], deq_slot[l*SLOT_W +: SLOT_W]}),
                longint'({el[l].insn, el[l].tag, el[l].slot}));
        end
        obs_n   = $countones(deq_valid);
        obs_rdy = enq_ready;
        for (int l = 0; l < DW; l++) obs_slot[l] = int'(deq_slot[l*SLOT_W +: SLOT_W]);
        if (flush) begin
            mq.delete();
        end else if (resteer_valid) begin
            j = -1;
            for (int i = 0; i < mq.size(); i++)
                if (j < 0 && mq[i].tag == resteer_tag && mq[i].slot == resteer_slot) j = i;
            if (j >= 0) while (mq.size() > j + 1) void'(mq.pop_back());
        end else begin
            if (skip_valid && skip_len >= 1 && skip_len <= MAX_SKIP)
                for (int i = 0; i < mq.size(); i++)
                    if (mq[i].tag == skip_tag && mq[i].slot > skip_slot &&
                        int'(mq[i].slot) <= int'(skip_slot) + int'(skip_len))
                        mq[i].live = 1'b0;
            if (!quiet && deq_ready) repeat (adv) void'(mq.pop_front());
            if (enq_valid && rdy && enq_cnt >= 1 && enq_cnt <= GMAX) begin
                for (int i = 0; i < int'(enq_cnt); i++) begin
                    ne.insn = enq_insn[i*IW +: IW];
                    ne.tag  = enq_tag;
                    ne.slot = SLOT_W'(i);
                    ne.live = 1'b1;
                    mq.push_back(ne);
                end
                next_tag = enq_tag + 1'b1;
            end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic drain(input string req);
        for (int g = 0; g < 12 && mq.size() > 0; g++) begin
            deq_ready = 1;
            cycle(req);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [TAG_W-1:0] t;
        int pick, r;
        void'($urandom(32'h5eed));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        #1;
        chk(deq_valid == '0, "R1", "deq_valid after reset", longint'(deq_valid), 0);
        chk(enq_ready == 1'b1, "R1", "enq_ready after reset", longint'(enq_ready), 1);
        @(negedge clk);

        // R2, R5: a full group drains over two cycles
        offer_group(16); cycle("R2");
        deq_ready = 1; cycle("R5");
        chk(obs_n == 8, "R5", "first drain lanes", obs_n, 8);
        deq_ready = 1; cycle("R5");
        chk(obs_n == 8, "R5", "second drain lanes", obs_n, 8);

        // R3: 17 entries leave fewer than GMAX free, a further group is refused
        offer_group(16); cycle("R3");
        offer_group(1);  cycle("R3");
        offer_group(16); cycle("R3");
        chk(obs_rdy == 1'b0, "R3", "ready with 17 stored", longint'(obs_rdy), 0);
        drain("R3");

        // R6, R12: resteer at slot 5 keeps six, drops the same-cycle group
        offer_group(12); t = next_tag; cycle("R6");
        resteer_valid = 1; resteer_tag = t; resteer_slot = 4'd5;
        offer_group(4); deq_ready = 1; cycle("R12");
        chk(obs_n == 0, "R12", "lanes during resteer", obs_n, 0);
        deq_ready = 1; cycle("R6");
        chk(obs_n == 6, "R6", "kept through branch", obs_n, 6);
        deq_ready = 1; cycle("R6");
        chk(obs_n == 0, "R6", "younger group gone", obs_n, 0);

        // R7: resteer naming nothing present
        offer_group(4); t = next_tag; cycle("R7");
        resteer_valid = 1; resteer_tag = t + 6'd20; resteer_slot = 4'd1; cycle("R7");
        deq_ready = 1; cycle("R7");
        chk(obs_n == 4, "R7", "contents unchanged", obs_n, 4);

        // R8: flush beats a same-cycle enqueue
        offer_group(10); cycle("R8");
        flush = 1; offer_group(5); cycle("R8");
        deq_ready = 1; cycle("R8");
        chk(obs_n == 0, "R8", "empty after flush", obs_n, 0);
        chk(obs_rdy == 1'b1, "R8", "ready after flush", longint'(obs_rdy), 1);

        // R9, R11, R12: skip slots 4 and 5 behind a branch at slot 3
        offer_group(16); t = next_tag; cycle("R9");
        skip_valid = 1; skip_tag = t; skip_slot = 4'd3; skip_len = 4'd2;
        deq_ready = 1; cycle("R12");
        chk(obs_n == 0, "R12", "lanes during skip", obs_n, 0);
        deq_ready = 1; cycle("R11");
        chk(obs_n == 8, "R11", "full width past hole", obs_n, 8);
        chk(obs_slot[3] == 3, "R9", "branch kept", obs_slot[3], 3);
        chk(obs_slot[4] == 6, "R9", "slot after hole", obs_slot[4], 6);
        deq_ready = 1; cycle("R9");
        chk(obs_n == 6, "R9", "remaining lanes", obs_n, 6);

        // R10: out-of-range skip lengths remove nothing
        offer_group(16); t = next_tag; cycle("R10");
        skip_valid = 1; skip_tag = t; skip_slot = 4'd2; skip_len = 4'd0; cycle("R10");
        skip_valid = 1; skip_tag = t; skip_slot = 4'd2; skip_len = 4'd5; cycle("R10");
        deq_ready = 1; cycle("R10");
        chk(obs_n == 8, "R10", "first half intact", obs_n, 8);
        deq_ready = 1; cycle("R10");
        chk(obs_n == 8, "R10", "second half intact", obs_n, 8);

        // R4: constrained random mix against the model
        for (int c = 0; c < 3000; c++) begin
            r = int'($urandom % 100);
            if (r < 2) flush = 1;
            else if (r < 7) begin
                resteer_valid = 1;
                if (mq.size() > 0 && ($urandom % 10) < 7) begin
                    pick = int'($urandom % mq.size());
                    resteer_tag = mq[pick].tag; resteer_slot = mq[pick].slot;
                end else begin
                    resteer_tag = next_tag + 6'd10; resteer_slot = SLOT_W'($urandom);
                end
            end else if (r < 15 && mq.size() > 0) begin
                pick = int'($urandom % mq.size());
                skip_valid = 1; skip_tag = mq[pick].tag; skip_slot = mq[pick].slot;
                skip_len = LEN_W'($urandom % 6);
            end
            deq_ready = (($urandom % 100) < 60);
            if (($urandom % 100) < 70) offer_group(1 + int'($urandom % GMAX));
            cycle("R4");
        end
        drain("R4");

        done = 1;
        summary();
        $finish;
    end
endmodule